// File: doc/BRIEF.md
# 64-bit Integer Execute Unit

This block is the integer execution stage of a 64-bit little-endian load/store processor. Each cycle it may accept one operation: a 5-bit function code, a first source operand, and a second operand. The second operand is either a full 64-bit register value or an 8-bit literal that is zero-extended to 64 bits. The block computes the result and registers it. The result and a valid flag appear one cycle after the operation is presented.

The function set covers several groups. Arithmetic is add and subtract, each in a 32-bit longword form and a 64-bit quadword form. Compares work on full quadwords and return exactly 1 or 0; five conditions are offered, signed and unsigned. There are six bitwise operations: three plain ones, and three that first invert the second operand. There are three shifts. A function code outside the defined set yields a zero result and raises an illegal-operation flag.

Top module: `ixu_top`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. While `rst` is high, `out_valid`, `result` and `illegal` are all 0.
- R2: With `use_lit` = 1, the second operand is `{56'b0, lit}` and `src_b` is ignored. With `use_lit` = 0, the second operand is `src_b`.
- R3: Code 1 (quad add) returns a+b modulo 2^64. Code 3 (quad subtract) returns a-b modulo 2^64.
- R4: Code 0 (long add) and code 2 (long subtract) compute bits 31:0 of a+b or a-b, then copy bit 31 of that value into bits 63:32.
- R5: The compare codes are 4 (equal), 5 (signed less-than), 6 (signed less-or-equal), 7 (unsigned less-than) and 8 (unsigned less-or-equal). Each returns 1 when its condition holds between a and the second operand, and 0 otherwise.
- R6: Code 9 returns a AND b, code 10 returns a OR b, and code 11 returns a XOR b.
- R7: Code 12 returns a AND NOT b, code 13 returns a OR NOT b, and code 14 returns NOT (a XOR b). In each case b is the second operand.
- R8: The shift amount is bits 5:0 of the second operand. Code 15 shifts left and code 16 shifts right logically, both filling with zeros. Code 17 shifts right and fills with copies of bit 63.
- R9: An accepted operation with a code from 18 to 31 gives `result` = 0 and `illegal` = 1. An accepted operation with a legal code gives `illegal` = 0.
- R10: A cycle with `in_valid` low leaves `result` and `illegal` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| func | input | 5 | Function code |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand, register form |
| use_lit | input | 1 | Select the literal as the second operand |
| lit | input | 8 | Literal, zero-extended to 64 bits |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered flag for an undefined function code |

## Verification
Every result is due exactly one rising edge after its operands are presented. There is a single output register stage and no other pipeline. The bench drives each operation on a falling edge and samples `out_valid`, `result` and `illegal` on the next falling edge, which is half a period after the capturing edge. The hold and reset checks sample the same way: one falling edge after the idle or reset cycle that should have left the outputs unchanged or cleared.

// File: rtl/ixu_pkg.sv
package ixu_pkg;
  localparam int FUNC_W = 5;

  typedef enum logic [FUNC_W-1:0] {
    OP_ADD_L   = 5'd0,
    OP_ADD_Q   = 5'd1,
    OP_SUB_L   = 5'd2,
    OP_SUB_Q   = 5'd3,
    OP_CMP_EQ  = 5'd4,
    OP_CMP_SLT = 5'd5,
    OP_CMP_SLE = 5'd6,
    OP_CMP_ULT = 5'd7,
    OP_CMP_ULE = 5'd8,
    OP_AND     = 5'd9,
    OP_OR      = 5'd10,
    OP_XOR     = 5'd11,
    OP_ANDN    = 5'd12,
    OP_ORN     = 5'd13,
    OP_XNOR    = 5'd14,
    OP_SHL     = 5'd15,
    OP_SHR     = 5'd16,
    OP_SRA     = 5'd17
  } op_e;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_SHIFT = 2'd2,
    GRP_BAD   = 2'd3
  } grp_e;

  function automatic grp_e op_group(input logic [FUNC_W-1:0] f);
    if (f <= 5'd8)       return GRP_ARITH;
    else if (f <= 5'd14) return GRP_LOGIC;
    else if (f <= 5'd17) return GRP_SHIFT;
    else                 return GRP_BAD;
  endfunction
endpackage

// File: rtl/ixu_operand.sv
module ixu_operand #(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8
) (
  input  logic [DATA_W-1:0] src_b,
  input  logic              use_lit,
  input  logic [LIT_W-1:0]  lit,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int PAD_W = DATA_W - LIT_W;

  always_comb begin
    if (use_lit) opnd_b = {{PAD_W{1'b0}}, lit};
    else         opnd_b = src_b;
  end
endmodule

// File: rtl/ixu_arith.sv
module ixu_arith
  import ixu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LONG_W = 32
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int EXT_W = DATA_W - LONG_W;

  logic              do_sub;
  logic [DATA_W-1:0] b_in;
  logic [DATA_W:0]   sum;
  logic              eq, ult, slt;
  logic [DATA_W-1:0] flag_word;

  // compares always subtract, so one adder serves every arithmetic code
  always_comb begin
    do_sub = !(func == OP_ADD_L || func == OP_ADD_Q);
    b_in   = do_sub ? ~b : b;
    sum    = {1'b0, a} + {1'b0, b_in} + {{DATA_W{1'b0}}, do_sub};
  end

  always_comb begin
    eq  = (a == b);
    ult = !sum[DATA_W];
    slt = (a[DATA_W-1] ^ b[DATA_W-1]) ? a[DATA_W-1] : sum[DATA_W-1];
  end

  always_comb begin
    flag_word = '0;
    case (func)
      OP_CMP_EQ:  flag_word[0] = eq;
      OP_CMP_SLT: flag_word[0] = slt;
      OP_CMP_SLE: flag_word[0] = slt | eq;
      OP_CMP_ULT: flag_word[0] = ult;
      OP_CMP_ULE: flag_word[0] = ult | eq;
      default:    flag_word[0] = 1'b0;
    endcase
  end

  always_comb begin
    case (func)
      OP_ADD_L, OP_SUB_L:
        y = {{EXT_W{sum[LONG_W-1]}}, sum[LONG_W-1:0]};
      OP_ADD_Q, OP_SUB_Q:
        y = sum[DATA_W-1:0];
      default:
        y = flag_word;
    endcase
  end
endmodule

// File: rtl/ixu_logic.sv
module ixu_logic
  import ixu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  logic              inv_b;
  logic [DATA_W-1:0] bx;

  always_comb begin
    inv_b = (func == OP_ANDN) || (func == OP_ORN) || (func == OP_XNOR);
    bx    = inv_b ? ~b : b;
  end

  always_comb begin
    case (func)
      OP_AND, OP_ANDN: y = a & bx;
      OP_OR,  OP_ORN:  y = a | bx;
      OP_XOR, OP_XNOR: y = a ^ bx;
      default:         y = '0;
    endcase
  end
endmodule

// File: rtl/ixu_shift.sv
module ixu_shift
  import ixu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [FUNC_W-1:0] func,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] fill_mask;
  logic [DATA_W-1:0] right_log;

  // arithmetic right = logical right with the vacated top bits forced to the sign
  always_comb begin
    amt       = b[SH_W-1:0];
    right_log = a >> amt;
    fill_mask = ~({DATA_W{1'b1}} >> amt);
  end

  always_comb begin
    case (func)
      OP_SHL:  y = a << amt;
      OP_SHR:  y = right_log;
      OP_SRA:  y = a[DATA_W-1] ? (right_log | fill_mask) : right_log;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/ixu_top.sv
module ixu_top
  import ixu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LONG_W = 32,
  parameter int LIT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [4:0]        func,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              use_lit,
  input  logic [LIT_W-1:0]  lit,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] y_arith, y_logic, y_shift;
  logic [DATA_W-1:0] y_next;
  logic              bad_next;
  grp_e              grp;

  ixu_operand #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_opnd (
    .src_b   (src_b),
    .use_lit (use_lit),
    .lit     (lit),
    .opnd_b  (opnd_b)
  );

  ixu_arith #(.DATA_W(DATA_W), .LONG_W(LONG_W)) u_arith (
    .func (func),
    .a    (src_a),
    .b    (opnd_b),
    .y    (y_arith)
  );

  ixu_logic #(.DATA_W(DATA_W)) u_logic (
    .func (func),
    .a    (src_a),
    .b    (opnd_b),
    .y    (y_logic)
  );

  ixu_shift #(.DATA_W(DATA_W)) u_shift (
    .func (func),
    .a    (src_a),
    .b    (opnd_b),
    .y    (y_shift)
  );

  always_comb begin
    grp      = op_group(func);
    bad_next = (grp == GRP_BAD);
    case (grp)
      GRP_ARITH: y_next = y_arith;
      GRP_LOGIC: y_next = y_logic;
      GRP_SHIFT: y_next = y_shift;
      default:   y_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= y_next;
        illegal <= bad_next;
      end
    end
  end
endmodule

// File: rtl/ixu_checker.sv
module ixu_checker #(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [4:0]        func,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              use_lit,
  input logic [LIT_W-1:0]  lit,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);
  logic [DATA_W-1:0] b_sel;
  assign b_sel = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit} : src_b;

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R5
  cmp_binary_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(func) >= 5'd4 && $past(func) <= 5'd8)
      |-> (result[DATA_W-1:1] == '0));

  // R5
  cmp_eq_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(func) == 5'd4 && $past(src_a) == $past(b_sel))
      |-> (result == {{(DATA_W-1){1'b0}}, 1'b1}));

  // R4
  long_ext_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && ($past(func) == 5'd0 || $past(func) == 5'd2))
      |-> (result[DATA_W-1:32] == {(DATA_W-32){result[31]}}));

  // R9
  bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0));

  // R9
  bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) |-> (illegal == ($past(func) >= 5'd18)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(result) && $stable(illegal)));
endmodule

bind ixu_top ixu_checker #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .func      (func),
  .src_a     (src_a),
  .src_b     (src_b),
  .use_lit   (use_lit),
  .lit       (lit),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/tb_ixu_top.sv
module tb_ixu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  func = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        use_lit = 1'b0;
  logic [7:0]  lit = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ixu_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
    .src_a(src_a), .src_b(src_b), .use_lit(use_lit), .lit(lit),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  typedef struct packed {
    logic [4:0]  f;
    logic        ul;
    logic [63:0] a;
    logic [63:0] b;
    logic [7:0]  l;
    logic        ill;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{5'd1,  1'b0, 64'd5, 64'd7, 8'd0, 1'b0, 64'd12, 4'd3},                                        // R3
    '{5'd3,  1'b0, 64'd3, 64'd5, 8'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 4'd3},                       // R3
    '{5'd1,  1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 1'b0, 64'd0, 4'd3},                       // R3
    '{5'd0,  1'b0, 64'h7FFF_FFFF, 64'd1, 8'd0, 1'b0, 64'hFFFF_FFFF_8000_0000, 4'd4},               // R4
    '{5'd2,  1'b0, 64'd0, 64'd1, 8'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd4},                       // R4
    '{5'd0,  1'b0, 64'h1_0000_0005, 64'd3, 8'd0, 1'b0, 64'd8, 4'd4},                               // R4
    '{5'd1,  1'b1, 64'd10, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, 64'h109, 4'd2},                   // R2
    '{5'd4,  1'b0, 64'd9, 64'd9, 8'd0, 1'b0, 64'd1, 4'd5},                                         // R5
    '{5'd4,  1'b0, 64'd9, 64'd8, 8'd0, 1'b0, 64'd0, 4'd5},                                         // R5
    '{5'd5,  1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 1'b0, 64'd1, 4'd5},                       // R5
    '{5'd7,  1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'd0, 1'b0, 64'd0, 4'd5},                       // R5
    '{5'd6,  1'b0, 64'd5, 64'd5, 8'd0, 1'b0, 64'd1, 4'd5},                                         // R5
    '{5'd8,  1'b0, 64'd6, 64'd5, 8'd0, 1'b0, 64'd0, 4'd5},                                         // R5
    '{5'd5,  1'b0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 8'd0, 1'b0, 64'd1, 4'd5},     // R5
    '{5'd7,  1'b1, 64'd3, 64'd0, 8'd4, 1'b0, 64'd1, 4'd2},                                         // R2
    '{5'd9,  1'b0, 64'hF0F0, 64'hFF00, 8'd0, 1'b0, 64'hF000, 4'd6},                                // R6
    '{5'd10, 1'b0, 64'h00F0, 64'h0F00, 8'd0, 1'b0, 64'h0FF0, 4'd6},                                // R6
    '{5'd11, 1'b0, 64'hFFFF, 64'h00FF, 8'd0, 1'b0, 64'hFF00, 4'd6},                                // R6
    '{5'd12, 1'b0, 64'hFFFF, 64'h00FF, 8'd0, 1'b0, 64'hFF00, 4'd7},                                // R7
    '{5'd13, 1'b0, 64'd0, 64'hFFFF_FFFF_FFFF_0000, 8'd0, 1'b0, 64'hFFFF, 4'd7},                    // R7
    '{5'd14, 1'b0, 64'h0F, 64'h0F, 8'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd7},                     // R7
    '{5'd15, 1'b0, 64'd1, 64'd63, 8'd0, 1'b0, 64'h8000_0000_0000_0000, 4'd8},                      // R8
    '{5'd15, 1'b0, 64'd1, 64'h44, 8'd0, 1'b0, 64'h10, 4'd8},                                       // R8
    '{5'd16, 1'b0, 64'h8000_0000_0000_0000, 64'd4, 8'd0, 1'b0, 64'h0800_0000_0000_0000, 4'd8},     // R8
    '{5'd17, 1'b0, 64'h8000_0000_0000_0000, 64'd4, 8'd0, 1'b0, 64'hF800_0000_0000_0000, 4'd8},     // R8
    '{5'd17, 1'b0, 64'h4000_0000_0000_0000, 64'd1, 8'd0, 1'b0, 64'h2000_0000_0000_0000, 4'd8},     // R8
    '{5'd17, 1'b1, 64'hFFFF_FFFF_FFFF_FF00, 64'd0, 8'd8, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8},     // R8
    '{5'd20, 1'b0, 64'd123, 64'd456, 8'd0, 1'b1, 64'd0, 4'd9}                                      // R9
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] f, input logic ul, input logic [63:0] a,
                       input logic [63:0] b, input logic [7:0] l);
    @(negedge clk);
    in_valid = 1'b1; func = f; use_lit = ul; src_a = a; src_b = b; lit = l;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    check("R1 reset illegal", {63'd0, illegal}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].f, VECS[i].ul, VECS[i].a, VECS[i].b, VECS[i].l);
      check($sformatf("R%0d vec %0d valid", VECS[i].req, i), {63'd0, out_valid}, 64'd1);
      check($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].exp);
      check($sformatf("R%0d vec %0d illegal", VECS[i].req, i), {63'd0, illegal}, {63'd0, VECS[i].ill});
    end

    // R1: valid drops one cycle after in_valid drops
    @(negedge clk);
    check("R1 idle out_valid", {63'd0, out_valid}, 64'd0);

    // R10: idle cycle with changed operands must not touch result/illegal
    func = 5'd1; src_a = 64'd99; src_b = 64'd1;
    @(negedge clk);
    check("R10 hold result", result, 64'd0);
    check("R10 hold illegal", {63'd0, illegal}, 64'd1);

    // R9: legal operation clears illegal
    issue(5'd11, 1'b0, 64'hA, 64'h5, 8'd0);
    check("R9 clear illegal", {63'd0, illegal}, 64'd0);
    check("R6 xor after illegal", result, 64'hF);

    // R9: highest code
    issue(5'd31, 1'b0, 64'hFF, 64'hFF, 8'd0);
    check("R9 code31 result", result, 64'd0);
    check("R9 code31 illegal", {63'd0, illegal}, 64'd1);

    // R2: literal ignores src_b under a logic op
    issue(5'd9, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h3C);
    check("R2 literal and", result, 64'h3C);

    // R1: back-to-back operations each valid
    @(negedge clk);
    in_valid = 1'b1; func = 5'd1; use_lit = 1'b0; src_a = 64'd1; src_b = 64'd1;
    @(negedge clk);
    check("R1 b2b first", result, 64'd2);
    func = 5'd3; src_a = 64'd10; src_b = 64'd4;
    @(negedge clk);
    check("R1 b2b second", result, 64'd6);
    check("R1 b2b valid", {63'd0, out_valid}, 64'd1);

    // R1: reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 midreset result", result, 64'd0);
    check("R1 midreset valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule